// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block gives a processor three 8-bit parallel ports through a small synchronous register window. Two address bits pick port A, port B, port C or a command register. A command byte either defines the direction of every port or sets or clears a single port C pin without touching the directions. Port C is split into two 4-bit halves, and each half has its own direction, so it can serve as one 8-bit port or as two 4-bit ports.

Each port pin has a driven value and an output enable, so a pad ring can build the tri-state pin. A port set as output drives its output latch onto the pins. A port set as input leaves its pins undriven, and reads of it return the live pin values. Only plain I/O and single-bit set/reset of port C are provided.

Bus accesses are sampled on the rising clock edge while `busSel` is high. Writes take effect on that edge. Read data is combinational and valid while `busSel` and `busRd` are high.

Top module: `par_io_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, all output enables are 0, so every port is an input, and all output latches hold 0.
- R2: The address picks the target: 2'b00 port A, 2'b01 port B, 2'b10 port C, 2'b11 command register. A read of address 2'b11 returns 8'h00.
- R3: A command write with bit 7 = 1 is a mode word. Bit 4 = 1 makes port A an input, bit 1 = 1 makes port B an input, bit 3 = 1 makes port C bits 7:4 an input, and bit 0 = 1 makes port C bits 3:0 an input. A 0 in any of these bits makes that port or half an output, with all of its enables at 1. Bits 6, 5 and 2 have no effect.
- R4: A mode word clears the output latches of all three ports to 0 from the next cycle.
- R5: A command write with bit 7 = 0 writes bit 0 into the port C latch bit numbered by bits 3:1. No other latch bit and no direction changes, and this holds even when that half of port C is an input.
- R6: A read of a port, or of a port C half, that is set as output returns its output latch. A read of one set as input returns its input pins. The two port C halves are chosen independently.
- R7: A data write to a port address loads that port's output latch whatever its direction. Output values change only after a write.
- R8: The mode word 8'h92 makes ports A and B inputs and all of port C an output.
- R9: With `busSel` low, writes have no effect and `busRdata` is 8'h00. `busRdata` is also 8'h00 whenever `busRd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busSel | input | 1 | Block select |
| busRd | input | 1 | Read request |
| busWr | input | 1 | Write request |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, 0 when no read is in progress |
| paIn | input | 8 | Port A pin values |
| paOut | output | 8 | Port A driven values |
| paOe | output | 8 | Port A output enables |
| pbIn | input | 8 | Port B pin values |
| pbOut | output | 8 | Port B driven values |
| pbOe | output | 8 | Port B output enables |
| pcIn | input | 8 | Port C pin values |
| pcOut | output | 8 | Port C driven values |
| pcOe | output | 8 | Port C output enables |

## Verification
The assertions assume that the bus inputs are stable around each rising edge and that reset is high for at least one edge before any access. The stimulus meets this by changing inputs one nanosecond after a rising edge and by holding reset for three edges. It never raises `busRd` and `busWr` together, and the pin inputs change only between accesses, so read data is sampled on the falling edge while it is settled. A behavioural model in the bench tracks the directions and latches and is compared on every falling edge.

// File: rtl/par_io_pkg.sv
package par_io_pkg;

  // Address codes (behaviour depends on this order)
  localparam logic [1:0] ADDR_PA   = 2'd0;
  localparam logic [1:0] ADDR_PB   = 2'd1;
  localparam logic [1:0] ADDR_PC   = 2'd2;
  localparam logic [1:0] ADDR_CMD  = 2'd3;

  // Command word field positions
  localparam int CMD_KIND_BIT = 7;  // 1: mode word, 0: single-bit op
  localparam int MODE_A_IN    = 4;
  localparam int MODE_B_IN    = 1;
  localparam int MODE_CHI_IN  = 3;
  localparam int MODE_CLO_IN  = 0;
  localparam int BIT_SEL_LO   = 1;
  localparam int BIT_VAL      = 0;

  localparam int NUM_AB = 2;

  typedef struct packed {
    logic              modeWr;
    logic              bitOp;
    logic [NUM_AB:0]   portWr;  // [0]=A [1]=B [2]=C
    logic              rdEn;
    logic [1:0]        rdPort;
  } ctrlStrobes_t;

endpackage

// File: rtl/par_io_ctrl.sv
module par_io_ctrl
  import par_io_pkg::*;
(
  input  logic         busSel,
  input  logic         busRd,
  input  logic         busWr,
  input  logic [1:0]   busAddr,
  input  logic         cmdKind,
  output ctrlStrobes_t stb
);

  logic wrAccess;
  logic cmdHit;

  assign wrAccess = busSel & busWr;
  assign cmdHit   = wrAccess & (busAddr == ADDR_CMD);

  assign stb.modeWr = cmdHit & cmdKind;
  assign stb.bitOp  = cmdHit & ~cmdKind;
  assign stb.rdEn   = busSel & busRd;
  assign stb.rdPort = busAddr;

  for (genvar p = 0; p <= NUM_AB; p++) begin : g_portWr
    assign stb.portWr[p] = wrAccess & (busAddr == 2'(p));
  end

endmodule

// File: rtl/par_io_datapath.sv
module par_io_datapath
  import par_io_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      stb,
  input  logic [PORT_W-1:0] wrData,
  input  logic [PORT_W-1:0] paPins,
  input  logic [PORT_W-1:0] pbPins,
  input  logic [PORT_W-1:0] pcPins,
  output logic [PORT_W-1:0] paDrive,
  output logic [PORT_W-1:0] pbDrive,
  output logic [PORT_W-1:0] pcDrive,
  output logic [PORT_W-1:0] paEn,
  output logic [PORT_W-1:0] pbEn,
  output logic [PORT_W-1:0] pcEn,
  output logic [PORT_W-1:0] rdData
);

  localparam int HALF_W = PORT_W / 2;
  localparam int SEL_W  = $clog2(PORT_W);

  logic [NUM_AB-1:0]             abIsIn;
  logic                          cHiIsIn;
  logic                          cLoIsIn;
  logic [NUM_AB-1:0][PORT_W-1:0] abLat;
  logic [NUM_AB-1:0][PORT_W-1:0] abPins;
  logic [NUM_AB-1:0][PORT_W-1:0] abView;
  logic [PORT_W-1:0]             cLat;
  logic [PORT_W-1:0]             cView;
  logic [SEL_W-1:0]              bitSel;

  assign abPins[0] = paPins;
  assign abPins[1] = pbPins;
  assign bitSel    = wrData[BIT_SEL_LO +: SEL_W];

  // Direction state
  always_ff @(posedge clk) begin
    if (rst) begin
      abIsIn  <= '1;
      cHiIsIn <= 1'b1;
      cLoIsIn <= 1'b1;
    end else if (stb.modeWr) begin
      abIsIn[0] <= wrData[MODE_A_IN];
      abIsIn[1] <= wrData[MODE_B_IN];
      cHiIsIn   <= wrData[MODE_CHI_IN];
      cLoIsIn   <= wrData[MODE_CLO_IN];
    end
  end

  // Ports A and B share one structure
  for (genvar p = 0; p < NUM_AB; p++) begin : g_ab
    always_ff @(posedge clk) begin
      if (rst || stb.modeWr) begin
        abLat[p] <= '0;
      end else if (stb.portWr[p]) begin
        abLat[p] <= wrData;
      end
    end
    assign abView[p] = abIsIn[p] ? abPins[p] : abLat[p];
  end

  // Port C latch: full write or single-bit op
  always_ff @(posedge clk) begin
    if (rst || stb.modeWr) begin
      cLat <= '0;
    end else if (stb.portWr[NUM_AB]) begin
      cLat <= wrData;
    end else if (stb.bitOp) begin
      cLat[bitSel] <= wrData[BIT_VAL];
    end
  end

  assign cView = {cHiIsIn ? pcPins[PORT_W-1:HALF_W] : cLat[PORT_W-1:HALF_W],
                  cLoIsIn ? pcPins[HALF_W-1:0]      : cLat[HALF_W-1:0]};

  assign paDrive = abLat[0];
  assign pbDrive = abLat[1];
  assign pcDrive = cLat;
  assign paEn    = {PORT_W{~abIsIn[0]}};
  assign pbEn    = {PORT_W{~abIsIn[1]}};
  assign pcEn    = {{HALF_W{~cHiIsIn}}, {HALF_W{~cLoIsIn}}};

  always_comb begin
    rdData = '0;
    if (stb.rdEn) begin
      case (stb.rdPort)
        ADDR_PA: rdData = abView[0];
        ADDR_PB: rdData = abView[1];
        ADDR_PC: rdData = cView;
        default: rdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/par_io_unit.sv
module par_io_unit
  import par_io_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busSel,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [1:0]        busAddr,
  input  logic [PORT_W-1:0] busWdata,
  output logic [PORT_W-1:0] busRdata,
  input  logic [PORT_W-1:0] paIn,
  output logic [PORT_W-1:0] paOut,
  output logic [PORT_W-1:0] paOe,
  input  logic [PORT_W-1:0] pbIn,
  output logic [PORT_W-1:0] pbOut,
  output logic [PORT_W-1:0] pbOe,
  input  logic [PORT_W-1:0] pcIn,
  output logic [PORT_W-1:0] pcOut,
  output logic [PORT_W-1:0] pcOe
);

  ctrlStrobes_t stb;

  par_io_ctrl u_ctrl (
    .busSel  (busSel),
    .busRd   (busRd),
    .busWr   (busWr),
    .busAddr (busAddr),
    .cmdKind (busWdata[CMD_KIND_BIT]),
    .stb     (stb)
  );

  par_io_datapath #(.PORT_W(PORT_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .wrData  (busWdata),
    .paPins  (paIn),
    .pbPins  (pbIn),
    .pcPins  (pcIn),
    .paDrive (paOut),
    .pbDrive (pbOut),
    .pcDrive (pcOut),
    .paEn    (paOe),
    .pbEn    (pbOe),
    .pcEn    (pcOe),
    .rdData  (busRdata)
  );

endmodule

// File: rtl/par_io_checker.sv
module par_io_checker #(
  parameter int PORT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              busSel,
  input logic              busRd,
  input logic              busWr,
  input logic [1:0]        busAddr,
  input logic              cmdKind,
  input logic [PORT_W-1:0] busRdata,
  input logic [PORT_W-1:0] paOut,
  input logic [PORT_W-1:0] pbOut,
  input logic [PORT_W-1:0] pcOut,
  input logic [PORT_W-1:0] paOe,
  input logic [PORT_W-1:0] pbOe,
  input logic [PORT_W-1:0] pcOe
);

  localparam int HALF_W = PORT_W / 2;

  logic cmdWr;
  logic anyWr;
  assign anyWr = busSel && busWr;
  assign cmdWr = anyWr && (busAddr == 2'd3);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (paOe == '0 && pbOe == '0 && pcOe == '0 &&
                    paOut == '0 && pbOut == '0 && pcOut == '0));

  // R3: each port, and each half of port C, switches as a whole
  assert_whole_dir_R3: assert property (@(posedge clk) disable iff (rst)
    (paOe == '0 || paOe == '1) && (pbOe == '0 || pbOe == '1) &&
    ($countones(pcOe[PORT_W-1:HALF_W]) == 0 || $countones(pcOe[PORT_W-1:HALF_W]) == HALF_W) &&
    ($countones(pcOe[HALF_W-1:0]) == 0 || $countones(pcOe[HALF_W-1:0]) == HALF_W));

  assert_mode_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (cmdWr && cmdKind) |=> (paOut == '0 && pbOut == '0 && pcOut == '0));

  assert_bitop_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    (cmdWr && !cmdKind) |=> ($stable(paOe) && $stable(pbOe) && $stable(pcOe) &&
                             $stable(paOut) && $stable(pbOut)));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !anyWr |=> ($stable(paOut) && $stable(pbOut) && $stable(pcOut) &&
                $stable(paOe) && $stable(pbOe) && $stable(pcOe)));

  assert_quiet_bus_R9: assert property (@(posedge clk) disable iff (rst)
    !(busSel && busRd) |-> busRdata == '0);

endmodule

bind par_io_unit par_io_checker #(.PORT_W(PORT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busSel   (busSel),
  .busRd    (busRd),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .cmdKind  (busWdata[7]),
  .busRdata (busRdata),
  .paOut    (paOut),
  .pbOut    (pbOut),
  .pcOut    (pcOut),
  .paOe     (paOe),
  .pbOe     (pbOe),
  .pcOe     (pcOe)
);

// File: tb/par_io_unit_bench.sv
`timescale 1ns/1ps
module par_io_unit_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busSel = 1'b0, busRd = 1'b0, busWr = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic [7:0] paIn = 8'h3C, pbIn = 8'hC5, pcIn = 8'hC3;
  logic [7:0] paOut, paOe, pbOut, pbOe, pcOut, pcOe;

  always #2.5 clk = ~clk;

  par_io_unit u_par_io_unit (
    .clk(clk), .rst(rst), .busSel(busSel), .busRd(busRd), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .paIn(paIn), .paOut(paOut), .paOe(paOe),
    .pbIn(pbIn), .pbOut(pbOut), .pbOe(pbOe),
    .pcIn(pcIn), .pcOut(pcOut), .pcOe(pcOe)
  );

  int checks = 0, fails = 0, cycChecks = 0, cycFails = 0;
  bit wdFail = 1'b0;

  // Behavioural reference model
  bit mAIn = 1, mBIn = 1, mCHiIn = 1, mCLoIn = 1;
  logic [7:0] mA = 0, mB = 0, mC = 0;

  always @(posedge clk) begin
    if (rst) begin
      mAIn = 1; mBIn = 1; mCHiIn = 1; mCLoIn = 1;
      mA = 0; mB = 0; mC = 0;
    end else if (busSel && busWr) begin
      if (busAddr == 0) mA = busWdata;
      else if (busAddr == 1) mB = busWdata;
      else if (busAddr == 2) mC = busWdata;
      else if (busWdata[7]) begin
        mAIn = busWdata[4]; mBIn = busWdata[1];
        mCHiIn = busWdata[3]; mCLoIn = busWdata[0];
        mA = 0; mB = 0; mC = 0;
      end else begin
        mC[busWdata[3:1]] = busWdata[0];
      end
    end
  end

  function automatic logic [7:0] expRead();
    logic [7:0] r;
    r = 8'h00;
    if (busSel && busRd) begin
      case (busAddr)
        2'd0: r = mAIn ? paIn : mA;
        2'd1: r = mBIn ? pbIn : mB;
        2'd2: r = {mCHiIn ? pcIn[7:4] : mC[7:4], mCLoIn ? pcIn[3:0] : mC[3:0]};
        default: r = 8'h00;
      endcase
    end
    return r;
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      logic [7:0] eOe;
      cycChecks++;
      if ({paOut, pbOut, pcOut} !== {mA, mB, mC}) begin
        cycFails++;
        $display("FAIL R7 model outputs actual=%h expected=%h", {paOut, pbOut, pcOut}, {mA, mB, mC});
      end
      cycChecks++;
      eOe = {{4{~mCHiIn}}, {4{~mCLoIn}}};
      if ({paOe, pbOe, pcOe} !== {{8{~mAIn}}, {8{~mBIn}}, eOe}) begin
        cycFails++;
        $display("FAIL R3 model enables actual=%h expected=%h", {paOe, pbOe, pcOe}, {{8{~mAIn}}, {8{~mBIn}}, eOe});
      end
      cycChecks++;
      if (busRdata !== expRead()) begin
        cycFails++;
        $display("FAIL R6 model read actual=%h expected=%h", busRdata, expRead());
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d, input logic sel = 1'b1);
    @(posedge clk); #1;
    busSel = sel; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 1'b0; busWr = 1'b0;
    @(negedge clk);
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d, input logic sel = 1'b1);
    @(posedge clk); #1;
    busSel = sel; busRd = 1'b1; busAddr = a;
    @(negedge clk);
    d = busRdata;
    @(posedge clk); #1;
    busSel = 1'b0; busRd = 1'b0;
  endtask

  task automatic runTests();
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 reset enables", paOe | pbOe | pcOe, 8'h00);
    chk("R1 reset latches", paOut | pbOut | pcOut, 8'h00);

    busWrite(2'd3, 8'h92);
    chk("R8 port A input", paOe, 8'h00);
    chk("R8 port B input", pbOe, 8'h00);
    chk("R8 port C output", pcOe, 8'hFF);

    busWrite(2'd2, 8'hA5);
    chk("R7 port C write", pcOut, 8'hA5);
    busWrite(2'd3, 8'h07);
    chk("R5 set bit 3", pcOut, 8'hAD);
    chk("R5 direction kept", pcOe, 8'hFF);
    busWrite(2'd3, 8'h0E);
    chk("R5 clear bit 7", pcOut, 8'h2D);

    busRead(2'd0, d);
    chk("R6 read input A", d, 8'h3C);
    busRead(2'd2, d);
    chk("R6 read output C", d, 8'h2D);
    busRead(2'd3, d);
    chk("R2 read command address", d, 8'h00);

    busWrite(2'd0, 8'h77);
    chk("R7 latch write while input", paOut, 8'h77);
    busRead(2'd0, d);
    chk("R6 input A still pins", d, 8'h3C);

    busWrite(2'd3, 8'h80);
    chk("R4 A latch cleared", paOut, 8'h00);
    chk("R4 C latch cleared", pcOut, 8'h00);
    chk("R3 A output", paOe, 8'hFF);

    busWrite(2'd1, 8'h5E);
    chk("R7 port B write", pbOut, 8'h5E);
    busRead(2'd1, d);
    chk("R6 read output B", d, 8'h5E);
    busRead(2'd0, d);
    chk("R6 read output A latch", d, 8'h00);

    busWrite(2'd0, 8'hFF, 1'b0);
    chk("R9 unselected write ignored", paOut, 8'h00);
    busRead(2'd1, d, 1'b0);
    chk("R9 unselected read zero", d, 8'h00);
    @(negedge clk);
    chk("R9 idle read data zero", busRdata, 8'h00);

    busWrite(2'd3, 8'h88);
    chk("R3 C upper input lower output", pcOe, 8'h0F);
    chk("R4 B latch cleared", pbOut, 8'h00);
    busWrite(2'd2, 8'h5A);
    busRead(2'd2, d);
    chk("R6 split C read", d, 8'hCA);

    busWrite(2'd3, 8'hE4);
    chk("R3 reserved bits no effect A", paOe, 8'hFF);
    chk("R3 reserved bits no effect C", pcOe, 8'hFF);
    busWrite(2'd3, 8'h0B);
    chk("R5 set bit 5", pcOut, 8'h20);

    busWrite(2'd3, 8'h9B);
    chk("R3 all inputs", paOe | pbOe | pcOe, 8'h00);
    busWrite(2'd3, 8'h03);
    chk("R5 op on input half", pcOut, 8'h02);
    chk("R5 input stays undriven", pcOe, 8'h00);
    busRead(2'd2, d);
    chk("R6 C input pins", d, 8'hC3);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    fork
      runTests();
      begin
        repeat (20000) @(posedge clk);
        wdFail = 1'b1;
      end
    join_any
    disable fork;
    if (wdFail) begin
      checks++; fails++;
      $display("FAIL watchdog actual=expired expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks + cycChecks, fails + cycFails);
    $finish;
  end

endmodule